// File: doc/BRIEF.md
# Inter-processor command dispatch register

This block is a single write-only command register through which software running on one core sends a control command to another core. Every write carries a 2-bit command kind, a 5-bit target core number and a 6-bit vector. The block decodes the word in the cycle of the write. In the next cycle it raises a one-cycle strobe for the chosen command, together with a one-hot select that names the target core. The four commands are: post an interrupt with a vector, request a reset, put the core into an idle state in which interrupts do not wake it, and resume an idled core.

Commands that name a core number at or above the number of populated cores are discarded. A reset command is legal only with the power-on-reset vector. Any other vector drops the command and sets a sticky error flag. Software reads the flag back at the same register and clears it by writing a word with its top bit set. The block only produces the strobes. The cores themselves are reset, halted and restarted elsewhere.

Top module: `ipi_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every strobe, `cpu_sel`, `post_vec` and the error flag (bit 0 of `rd_data`) are zero.
- R2: A write (`wr_en` high) with bit 63 clear is a command. The command kind is taken from bits 17:16, the target core from bits 12:8 and the vector from bits 5:0. All other bits are ignored.
- R3: A command of kind 0 to a populated core raises `post_stb` for one cycle, in the cycle after the write. In that cycle `post_vec` equals the written vector and `cpu_sel` has exactly the target's bit set.
- R4: A command of kind 1 whose vector equals `POR_VEC` raises `reset_stb` and the target's `cpu_sel` bit for one cycle, in the cycle after the write.
- R5: A command of kind 1 to a populated core whose vector differs from `POR_VEC` raises no strobe. From the cycle after the write, it sets the error flag, which is bit 0 of `rd_data`.
- R6: A command of kind 2 raises `halt_stb` and the target's `cpu_sel` bit for one cycle, in the cycle after the write.
- R7: A command of kind 3 raises `resume_stb` and the target's `cpu_sel` bit for one cycle, in the cycle after the write.
- R8: A command whose target is not below `NCPU` raises no strobe and leaves the error flag unchanged, whatever its kind and vector.
- R9: The error flag is sticky: later commands do not clear it. A write with bit 63 set clears it from the next cycle, and that write dispatches nothing.
- R10: At most one strobe is high in any cycle, and each strobe lasts one cycle per write. When no strobe is high, `cpu_sel` and `post_vec` are zero. All `rd_data` bits other than bit 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command register |
| wr_data | input | 64 | Written command word |
| rd_data | output | 64 | Read value of the register; bit 0 is the error flag |
| cpu_sel | output | NCPU | One-hot target core, valid with a strobe |
| post_stb | output | 1 | Interrupt post strobe |
| post_vec | output | 6 | Vector carried with `post_stb` |
| reset_stb | output | 1 | Reset request strobe |
| halt_stb | output | 1 | Idle request strobe |
| resume_stb | output | 1 | Resume request strobe |

## Verification
The bench builds the block with `NCPU` = 5 and `POR_VEC` = 0x02. Because only five cores are populated, target numbers 5 through 31 are legal encodings that the block must discard, so the out-of-range drop for every command kind can be exercised. The non-default reset vector means a design that compares against a fixed value instead of the parameter sets the error flag on a legal reset, and the bench catches that. Target 4 is the highest populated core, so the edge of the one-hot select is covered.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int          NCPU    = 32,
  parameter logic [5:0]  POR_VEC = 6'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [63:0]     wr_data,
  output logic [63:0]     rd_data,
  output logic [NCPU-1:0] cpu_sel,
  output logic            post_stb,
  output logic [5:0]      post_vec,
  output logic            reset_stb,
  output logic            halt_stb,
  output logic            resume_stb
);
  localparam int IDW = 5;
  localparam int VW  = 6;

  logic            err_q;
  logic [NCPU-1:0] sel_nxt;

  wire           clr_wr   = wr_en & wr_data[63];
  wire           cmd_wr   = wr_en & ~wr_data[63];
  wire [1:0]     kind     = wr_data[17:16];
  wire [IDW-1:0] tgt      = wr_data[12:8];
  wire [VW-1:0]  vec      = wr_data[VW-1:0];
  wire           in_range = int'(tgt) < NCPU;
  wire           go       = cmd_wr & in_range;
  wire           bad_rst  = go & (kind == 2'd1) & (vec != POR_VEC);
  wire           fire     = go & ~bad_rst;

  always_comb begin
    for (int i = 0; i < NCPU; i++)
      sel_nxt[i] = fire && (int'(tgt) == i);
  end

  assign rd_data = {63'd0, err_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_stb   <= 1'b0;
      reset_stb  <= 1'b0;
      halt_stb   <= 1'b0;
      resume_stb <= 1'b0;
      post_vec   <= '0;
      cpu_sel    <= '0;
      err_q      <= 1'b0;
    end else begin
      post_stb   <= fire && kind == 2'd0;
      reset_stb  <= fire && kind == 2'd1;
      halt_stb   <= fire && kind == 2'd2;
      resume_stb <= fire && kind == 2'd3;
      post_vec   <= (fire && kind == 2'd0) ? vec : '0;
      cpu_sel    <= sel_nxt;
      if (clr_wr)       err_q <= 1'b0;
      else if (bad_rst) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int         NCPU    = 32,
  parameter logic [5:0] POR_VEC = 6'h01
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [63:0]     wr_data,
  input logic [63:0]     rd_data,
  input logic [NCPU-1:0] cpu_sel,
  input logic            post_stb,
  input logic [5:0]      post_vec,
  input logic            reset_stb,
  input logic            halt_stb,
  input logic            resume_stb
);
  wire any_stb = post_stb | reset_stb | halt_stb | resume_stb;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({post_stb, reset_stb, halt_stb, resume_stb}));

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $countones(cpu_sel) == 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb |-> (cpu_sel == '0 && post_vec == '0));

  assert_strobe_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[63] && !(wr_data[17:16] == 2'd1 && wr_data[5:0] != POR_VEC)
      && int'(wr_data[12:8]) < NCPU |=> any_stb);

  assert_post_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[63] && wr_data[17:16] == 2'd0 && int'(wr_data[12:8]) < NCPU
      |=> post_stb && post_vec == $past(wr_data[5:0]));

  assert_err_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> $past(wr_en && !wr_data[63] && wr_data[17:16] == 2'd1));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[63] |=> !rd_data[0] && !any_stb);

  assert_drop_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[63] && int'(wr_data[12:8]) >= NCPU |=> !any_stb && $stable(rd_data[0]));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NCPU(NCPU), .POR_VEC(POR_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .cpu_sel(cpu_sel), .post_stb(post_stb), .post_vec(post_vec),
  .reset_stb(reset_stb), .halt_stb(halt_stb), .resume_stb(resume_stb)
);

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb;
  localparam int         NCPU    = 5;
  localparam logic [5:0] POR_VEC = 6'h02;

  typedef struct packed {
    logic [3:0]      stb;
    logic [NCPU-1:0] sel;
    logic [5:0]      vec;
    logic            err;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [63:0]     wr_data = '0;
  logic [63:0]     rd_data;
  logic [NCPU-1:0] cpu_sel;
  logic            post_stb, reset_stb, halt_stb, resume_stb;
  logic [5:0]      post_vec;

  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];
  string tags[$];
  logic err_model = 1'b0;

  always #4 clk = ~clk;

  ipi_dispatch #(.NCPU(NCPU), .POR_VEC(POR_VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cpu_sel(cpu_sel), .post_stb(post_stb), .post_vec(post_vec),
    .reset_stb(reset_stb), .halt_stb(halt_stb), .resume_stb(resume_stb)
  );

  function automatic exp_t observe();
    exp_t o;
    o.stb = {post_stb, reset_stb, halt_stb, resume_stb};
    o.sel = cpu_sel;
    o.vec = post_vec;
    o.err = rd_data[0];
    return o;
  endfunction

  task automatic compare(string tag, exp_t e);
    exp_t a = observe();
    n_chk++;
    if (a !== e || rd_data[63:1] !== '0) begin
      n_bad++;
      $display("FAIL %s: got stb=%b sel=%b vec=%h err=%b hi=%0h, expected stb=%b sel=%b vec=%h err=%b",
               tag, a.stb, a.sel, a.vec, a.err, rd_data[63:1], e.stb, e.sel, e.vec, e.err);
    end
  endtask

  // monitor: one expected item per clock edge while the queue is non-empty
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(tags.pop_front(), q.pop_front());
  end

  task automatic send(string tag, logic clr, logic [1:0] kind, logic [4:0] tgt,
                      logic [5:0] vec, logic [63:0] junk);
    exp_t e;
    exp_t idle;
    logic live;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = junk;
    wr_data[63] = clr;
    wr_data[17:16] = kind;
    wr_data[12:8] = tgt;
    wr_data[5:0] = vec;
    live = !clr && int'(tgt) < NCPU;
    e = '0;
    if (clr) err_model = 1'b0;
    else if (live && kind == 2'd1 && vec != POR_VEC) err_model = 1'b1;
    else if (live) begin
      e.stb = 4'b1000 >> kind;
      e.sel = NCPU'(1) << tgt;
      if (kind == 2'd0) e.vec = vec;
    end
    e.err = err_model;
    idle = '0;
    idle.err = err_model;
    q.push_back(e);    tags.push_back(tag);
    q.push_back(idle); tags.push_back({tag, " one-cycle R10"});
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // bits 62:18, 15:13 and 7:6 set, all ignored by the decode
  localparam logic [63:0] JUNK = 64'h7FFF_FFFF_FFFC_E0C0;

  initial begin
    repeat (3) @(negedge clk);
    compare("reset hold R1", exp_t'(0));
    rst_n = 1'b1;
    @(negedge clk);
    compare("after reset R1", exp_t'(0));

    send("post cpu3 R3",              1'b0, 2'd0, 5'd3,  6'h2A, '0);
    send("post cpu0 R3",              1'b0, 2'd0, 5'd0,  6'h3F, '0);
    send("reset por cpu4 R4",         1'b0, 2'd1, 5'd4,  6'h02, '0);
    send("halt cpu2 R6",              1'b0, 2'd2, 5'd2,  6'h00, '0);
    send("resume cpu2 R7",            1'b0, 2'd3, 5'd2,  6'h11, '0);
    send("out of range no err R8",    1'b0, 2'd1, 5'd31, 6'h05, '0);
    send("bad reset vec R5",          1'b0, 2'd1, 5'd1,  6'h01, '0);
    send("err sticky over post R9",   1'b0, 2'd0, 5'd4,  6'h07, '0);
    send("out of range post R8",      1'b0, 2'd0, 5'd5,  6'h09, '0);
    send("out of range halt R8",      1'b0, 2'd2, 5'd17, 6'h00, '0);
    send("clear err no dispatch R9",  1'b1, 2'd0, 5'd1,  6'h04, '0);
    send("junk bits ignored R2",      1'b0, 2'd0, 5'd1,  6'h05, JUNK);
    send("junk bits resume R2",       1'b0, 2'd3, 5'd0,  6'h00, JUNK);
    send("reset non-default vec R5",  1'b0, 2'd1, 5'd0,  6'h3F, JUNK);
    send("clear with junk R9",        1'b1, 2'd2, 5'd3,  6'h00, JUNK);
    send("reset after clear R4",      1'b0, 2'd1, 5'd1,  6'h02, JUNK);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule